// File: doc/BRIEF.md
# Stochastic Solver Run Controller

This block sequences the attempts of a randomised relaxation array that searches for a satisfying truth assignment. On a start request it seeds the array with a pseudo-random assignment, lets the array run, and counts the clock cycles the array needs until it raises its solved flag. When the flag rises, the block keeps the exact cycle count and the assignment the array settled on.

Each attempt has a cycle budget. When an attempt uses up its budget, the block does one of two things. It can report failure. It can also derive a fresh seed by stepping an LFSR and start a new attempt, up to a set number of attempts. A test host can rerun the same instance with many seeds and collect a distribution of solve times, one completion pulse per run.

Top module: `sat_run_ctrl`

## Requirements
- R1: After reset, done_o, success_o, array_load_o and array_run_o are 0, and cycles_o, attempts_o and solution_o are 0.
- R2: A start_i sampled while idle causes a single cycle with array_load_o high, in which array_init_o carries seed_i. A seed of 0 is loaded as the value 1. array_run_o rises in the next cycle.
- R3: A start_i sampled while a run is in progress has no effect: the seed, the counting and the result of that run are unchanged.
- R4: If solved_i is sampled high in the k-th cycle of an attempt's run phase, the block ends with success_o=1 and cycles_o=k. solution_o is the value of solution_i in that cycle.
- R5: With cycle_limit_i=L>0, an attempt in which solved_i is not seen within L run cycles times out after its L-th run cycle. solved_i in the L-th cycle still counts as success.
- R6: cycle_limit_i=0 means the attempt has no cycle budget.
- R7: On a timeout with auto_restart_i=0, the run ends with success_o=0, cycles_o=L and attempts_o=1.
- R8: On a timeout with auto_restart_i=1, a new attempt starts when attempts_o is below attempt_limit_i (a limit of 0 counts as 1). attempts_o increments, and the seed advances one right-shift Galois LFSR step: s>>1, XORed with 16'hB400 when bit 0 of s was 1. Otherwise the run fails with attempts_o equal to the limit.
- R9: done_o is high for exactly one cycle per run. success_o, cycles_o, attempts_o and solution_o hold until the next accepted start. That start clears success_o and cycles_o and sets attempts_o to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a run (accepted only when idle) |
| seed_i | input | N_VARS | Seed for the first attempt |
| cycle_limit_i | input | CNT_W | Run cycles allowed per attempt, 0 = no limit |
| attempt_limit_i | input | ATT_W | Maximum attempts with auto restart |
| auto_restart_i | input | 1 | Reseed and retry on timeout |
| solved_i | input | 1 | Array reports all clauses satisfied |
| solution_i | input | N_VARS | Array's current assignment |
| array_load_o | output | 1 | Load array_init_o into the array |
| array_init_o | output | N_VARS | Initial assignment for the attempt |
| array_run_o | output | 1 | Array may flip variables |
| done_o | output | 1 | One-cycle completion pulse |
| success_o | output | 1 | Last run found a solution |
| cycles_o | output | CNT_W | Run cycles of the final attempt |
| attempts_o | output | ATT_W | Attempts used |
| solution_o | output | N_VARS | Captured satisfying assignment |

## Verification
A wrong cycle counter shows in cycles_o on the first completed run. A solve that ends one cycle early or late gives a count off by one. A wrong limit compare shows as a timeout at the wrong run length. A corrupted seed register or LFSR step shows in solution_o, because the array model returns a fixed transform of the assignment it was loaded with. An attempt counter that is wrong shows in attempts_o, or as a run that ends one attempt too soon or too late. A controller stuck outside idle never pulses done_o, and the watchdog catches it.

// File: rtl/sat_run_pkg.sv
package sat_run_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_RUN,
    ST_SOLVED,
    ST_FAIL
  } run_state_t;
endpackage

// File: rtl/seed_gen.sv
// Holds the current attempt seed; loads from the host seed or advances by
// one Galois LFSR step. A zero seed is replaced by 1 so the LFSR never locks.
module seed_gen #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         advance_i,
  output logic [W-1:0] seed_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] step;
  assign step = (seed_o >> 1) ^ (seed_o[0] ? TAPS : '0);

  always_ff @(posedge clk) begin
    if (rst)            seed_o <= ONE;
    else if (load_i)    seed_o <= (seed_i == '0) ? ONE : seed_i;
    else if (advance_i) seed_o <= step;
  end

  // R8
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    seed_o != '0);
endmodule

// File: rtl/cycle_counter.sv
// Counts run cycles of one attempt and flags the last allowed cycle.
module cycle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] next_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count;

  assign next_o   = count + 1'b1;
  assign expire_o = (limit_i != '0) && (next_o == limit_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i) count <= '0;
    else if (inc_i)     count <= next_o;
  end

  // R5
  count_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && limit_i != '0) |-> (count < limit_i));
endmodule

// File: rtl/sat_run_ctrl.sv
module sat_run_ctrl
  import sat_run_pkg::*;
#(
  parameter int               N_VARS = 16,
  parameter int               CNT_W  = 32,
  parameter int               ATT_W  = 8,
  parameter logic [N_VARS-1:0] TAPS  = 16'hB400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [N_VARS-1:0] seed_i,
  input  logic [CNT_W-1:0]  cycle_limit_i,
  input  logic [ATT_W-1:0]  attempt_limit_i,
  input  logic              auto_restart_i,
  input  logic              solved_i,
  input  logic [N_VARS-1:0] solution_i,
  output logic              array_load_o,
  output logic [N_VARS-1:0] array_init_o,
  output logic              array_run_o,
  output logic              done_o,
  output logic              success_o,
  output logic [CNT_W-1:0]  cycles_o,
  output logic [ATT_W-1:0]  attempts_o,
  output logic [N_VARS-1:0] solution_o
);
  localparam logic [ATT_W-1:0] ONE_ATT = {{(ATT_W-1){1'b0}}, 1'b1};

  run_state_t       state;
  logic             accept, restart, expire;
  logic [CNT_W-1:0] cnt_next;
  logic [ATT_W-1:0] att_max;

  assign accept  = (state == ST_IDLE) && start_i;
  assign att_max = (attempt_limit_i == '0) ? ONE_ATT : attempt_limit_i;
  assign restart = (state == ST_RUN) && !solved_i && expire &&
                   auto_restart_i && (attempts_o < att_max);

  assign array_load_o = (state == ST_INIT);
  assign array_run_o  = (state == ST_RUN);

  seed_gen #(.W(N_VARS), .TAPS(TAPS)) u_seed (
    .clk(clk), .rst(rst), .load_i(accept), .seed_i(seed_i),
    .advance_i(restart), .seed_o(array_init_o)
  );

  cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear_i(array_load_o), .inc_i(array_run_o),
    .limit_i(cycle_limit_i), .next_o(cnt_next), .expire_o(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      done_o     <= 1'b0;
      success_o  <= 1'b0;
      cycles_o   <= '0;
      attempts_o <= '0;
      solution_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          state      <= ST_INIT;
          success_o  <= 1'b0;
          cycles_o   <= '0;
          attempts_o <= ONE_ATT;
        end
        ST_INIT: state <= ST_RUN;
        ST_RUN: begin
          if (solved_i) begin
            state      <= ST_SOLVED;
            done_o     <= 1'b1;
            success_o  <= 1'b1;
            cycles_o   <= cnt_next;
            solution_o <= solution_i;
          end else if (expire) begin
            cycles_o <= cnt_next;
            if (restart) begin
              attempts_o <= attempts_o + 1'b1;
              state      <= ST_INIT;
            end else begin
              done_o <= 1'b1;
              state  <= ST_FAIL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R2
  load_then_run_chk: assert property (@(posedge clk) disable iff (rst)
    array_load_o |=> array_run_o);
  // R4
  solved_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (array_run_o && solved_i) |=> (done_o && success_o));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> ($stable(success_o) && $stable(cycles_o)));
endmodule

// File: tb/sim_sat_run_ctrl.sv
module sim_sat_run_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MASK = 16'h5A3C;

  typedef struct {
    bit          succ;
    int          cyc;
    int          att;
    logic [15:0] sol;
    string       tag;
  } exp_t;

  logic        clk = 0, rst = 1, start_i = 0, auto_restart_i = 0, solved_i = 0;
  logic [15:0] seed_i = 0, solution_i = 0;
  logic [31:0] cycle_limit_i = 0;
  logic [7:0]  attempt_limit_i = 0;
  logic        array_load_o, array_run_o, done_o, success_o;
  logic [15:0] array_init_o, solution_o;
  logic [31:0] cycles_o;
  logic [7:0]  attempts_o;

  int   checks = 0, failures = 0, done_count = 0, cycle_ctr = 0;
  int   tgt [4];
  int   att_idx = 0, runcnt = 0;
  logic [15:0] init_cap = 0;
  exp_t q[$];
  bit   hold_chk = 0;
  bit   hold_succ;
  logic [31:0] hold_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_run_ctrl u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .seed_i(seed_i),
    .cycle_limit_i(cycle_limit_i), .attempt_limit_i(attempt_limit_i),
    .auto_restart_i(auto_restart_i), .solved_i(solved_i), .solution_i(solution_i),
    .array_load_o(array_load_o), .array_init_o(array_init_o), .array_run_o(array_run_o),
    .done_o(done_o), .success_o(success_o), .cycles_o(cycles_o),
    .attempts_o(attempts_o), .solution_o(solution_o)
  );

  function automatic logic [15:0] step(logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Array model: solves on the target run cycle of each attempt (0 = never).
  always @(negedge clk) begin
    if (array_load_o) begin
      att_idx++;
      runcnt   = 0;
      init_cap = array_init_o;
      solved_i = 0;
    end else if (array_run_o) begin
      runcnt++;
      solution_i = init_cap ^ MASK;
      solved_i = (att_idx >= 1 && att_idx <= 4 && tgt[att_idx-1] != 0 &&
                  runcnt == tgt[att_idx-1]);
    end else solved_i = 0;
  end

  // Monitor: pops expected results on each done pulse.
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (hold_chk) begin
        hold_chk = 0;
        check(done_o == 0, "R9", "done width", done_o, 0);
        check(success_o == hold_succ && cycles_o == hold_cyc, "R9", "hold",
              cycles_o, hold_cyc);
      end
      if (done_o) begin
        done_count++;
        if (q.size() == 0) check(0, "R9", "unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          check(success_o == e.succ, e.tag, "success", success_o, e.succ);
          check(cycles_o == e.cyc, e.tag, "cycles", cycles_o, e.cyc);
          check(attempts_o == e.att, e.tag, "attempts", attempts_o, e.att);
          if (e.succ) check(solution_o == e.sol, e.tag, "solution", solution_o, e.sol);
          hold_chk  = 1;
          hold_succ = success_o;
          hold_cyc  = cycles_o;
        end
      end
    end
  end

  task automatic run_case(logic [15:0] seed, int lim, int alim, bit auto_r,
                          int t0, int t1, int t2, int t3, exp_t e);
    int target = done_count + 1;
    tgt[0] = t0; tgt[1] = t1; tgt[2] = t2; tgt[3] = t3;
    att_idx = 0;
    seed_i = seed; cycle_limit_i = lim; attempt_limit_i = alim[7:0];
    auto_restart_i = auto_r;
    q.push_back(e);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    while (done_count < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic exp_t mk(bit s, int c, int a, logic [15:0] sol, string tag);
    exp_t e;
    e.succ = s; e.cyc = c; e.att = a; e.sol = sol; e.tag = tag;
    return e;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(done_o == 0 && success_o == 0 && array_load_o == 0 && array_run_o == 0,
          "R1", "control outputs", {done_o, success_o, array_load_o, array_run_o}, 0);
    check(cycles_o == 0 && attempts_o == 0 && solution_o == 0, "R1", "values",
          cycles_o, 0);

    // R2 load pulse and seed, R4 solve at cycle 5
    fork
      run_case(16'h1234, 100, 1, 0, 5, 0, 0, 0, mk(1, 5, 1, 16'h1234 ^ MASK, "R4"));
      begin
        @(posedge array_load_o); @(negedge clk);
        check(array_init_o == 16'h1234, "R2", "init value", array_init_o, 16'h1234);
        @(negedge clk);
        check(array_run_o == 1 && array_load_o == 0, "R2", "run follows load",
              array_run_o, 1);
      end
    join

    // R5 solved in the last allowed cycle wins
    run_case(16'h00F1, 7, 1, 0, 7, 0, 0, 0, mk(1, 7, 1, 16'h00F1 ^ MASK, "R5"));
    // R7 timeout, no restart
    run_case(16'hBEEF, 10, 4, 0, 0, 0, 0, 0, mk(0, 10, 1, 0, "R7"));
    // R8 restart, solve on third attempt with stepped seed
    run_case(16'hACE1, 6, 4, 1, 0, 0, 3, 0,
             mk(1, 3, 3, step(step(16'hACE1)) ^ MASK, "R8"));
    // R8 attempts exhausted
    run_case(16'h0F0F, 4, 3, 1, 0, 0, 0, 0, mk(0, 4, 3, 0, "R8"));
    // R8 attempt limit 0 counts as 1
    run_case(16'h0F0F, 4, 0, 1, 0, 0, 0, 0, mk(0, 4, 1, 0, "R8"));
    // R6 unlimited budget
    run_case(16'h7777, 0, 1, 0, 300, 0, 0, 0, mk(1, 300, 1, 16'h7777 ^ MASK, "R6"));
    // R2 zero seed loads as 1
    run_case(16'h0000, 50, 1, 0, 2, 0, 0, 0, mk(1, 2, 1, 16'h0001 ^ MASK, "R2"));

    // R3 start while busy ignored; R9 start clears results
    fork
      run_case(16'h4321, 0, 1, 0, 40, 0, 0, 0, mk(1, 40, 1, 16'h4321 ^ MASK, "R3"));
      begin
        @(posedge array_load_o); @(negedge clk);
        check(success_o == 0 && cycles_o == 0 && attempts_o == 1, "R9",
              "cleared at start", cycles_o, 0);
        repeat (10) @(negedge clk);
        seed_i = 16'h9999; start_i = 1;
        @(negedge clk); start_i = 0;
        check(array_run_o == 1 && array_load_o == 0, "R3", "still running",
              array_run_o, 1);
      end
    join

    check(q.size() == 0, "R9", "pending results", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycle_ctr++;
    if (cycle_ctr > 150000) begin
      checks++; failures++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cycle_ctr, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule